// File: doc/BRIEF.md
# Cursor Generator Host Register Port

This block is the host-facing register front end of a hardware cursor generator. The host sees four 16-bit word ports, picked by a 2-bit port code. Two of the ports load the low byte and the high byte of one shared 16-bit address pointer. The other two are data ports. One reads and writes 8-bit control registers at the pointer. The other reads and writes 16-bit words of the 512-entry cursor-map RAM at the same pointer.

Every data access advances the pointer by one. Software can therefore load an address once and then stream a run of registers or map words. The block holds the thirteen control registers. It presents their decoded fields (the enables, the combine mode, the mux mode, the thickness and six 12-bit coordinates) to a separate pixel stage. It also drives the read and write port of the external synchronous cursor-map RAM.

A request is held on `host_req` until `host_ready` is high. Every access completes in the cycle it is presented, except a map read. A map read completes one cycle later, carrying the RAM's registered output.

Top module: `cursor_regport`

## Requirements
- R1: Port 0 replaces the pointer's low byte and port 1 replaces its high byte. Each takes bits [7:0] of the written word and ignores bits [15:8], and the other pointer byte keeps its value. An address load does not advance the pointer.
- R2: A control-register read through port 3 completes in the request cycle. It returns the 8-bit value on both halves of `host_rdata`. A control-register write uses only bits [7:0] of `host_wdata`.
- R3: The control registers sit at pointer values 0x0000 to 0x000C, in this order: command, cursor X low, cursor X high, cursor Y low, cursor Y high, window X low, window X high, window Y low, window Y high, window width low, window width high, window height low, window height high. Each 12-bit coordinate output is {high[3:0], low[7:0]}.
- R4: The six high-byte coordinate registers keep only their low 4 bits. A read of one of them returns zero in bits [7:4] of each byte.
- R5: Every accepted access through port 2 or port 3, read or write, advances the pointer by exactly one.
- R6: The pointer wraps from 0xFFFF to 0x0000 on a data access.
- R7: A map write through port 2 completes in the request cycle. It pulses `map_we` for one cycle, with `map_addr` equal to pointer bits [8:0] and all 16 bits of `host_wdata` on `map_wdata`.
- R8: A map read through port 2 pulses `map_re`, with `map_addr` equal to pointer bits [8:0]. `host_ready` follows in the next cycle, with `host_rdata` equal to `map_rdata`. No new access is taken in that waiting cycle.
- R9: The command register drives the outputs from these bits: bit 6 is `cursor_en`, bit 5 is `xhair_en`, bit 4 is `or_combine` (1 selects OR, 0 selects XOR), bits [3:2] are `mux_mode` (0 is 1:1, 1 is 4:1, 2 is 5:1) and bits [1:0] are `xhair_thick` (0 to 3 stand for 1, 3, 5 and 7 pixels).
- R10: A port 3 write at any pointer value from 0x000D to 0xFFFF changes no register. A port 3 read there returns 0x0000.
- R11: Reset clears the pointer and every control register, so the cursor and the crosshair start disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Access request, held until host_ready |
| host_we | input | 1 | 1 for write, 0 for read |
| host_port | input | 2 | 0 pointer low, 1 pointer high, 2 cursor map, 3 control register |
| host_wdata | input | 16 | Write word |
| host_ready | output | 1 | Access completes this cycle |
| host_rdata | output | 16 | Read word, valid with host_ready |
| map_re | output | 1 | Cursor-map RAM read strobe |
| map_we | output | 1 | Cursor-map RAM write strobe |
| map_addr | output | 9 | Cursor-map RAM word address |
| map_wdata | output | 16 | Cursor-map RAM write word |
| map_rdata | input | 16 | Cursor-map RAM registered read word |
| cursor_en | output | 1 | Cursor enable |
| xhair_en | output | 1 | Crosshair enable |
| or_combine | output | 1 | 1 selects OR combining, 0 selects XOR |
| mux_mode | output | 2 | Pixel mux mode |
| xhair_thick | output | 2 | Crosshair thickness code |
| cursor_x | output | 12 | Cursor X position |
| cursor_y | output | 12 | Cursor Y position |
| win_x | output | 12 | Crosshair window X |
| win_y | output | 12 | Crosshair window Y |
| win_w | output | 12 | Crosshair window width |
| win_h | output | 12 | Crosshair window height |

## Verification
Every data access does two things in one clock edge: it updates a register or strobes the map RAM, and it advances the pointer. The bench provokes this by streaming back-to-back accesses after a single address load, across the end of the control range, across the 0x1FF map boundary and across the 0xFFFF pointer wrap. It judges each stream by re-loading the address and reading the values back through a scoreboard queue. The decoded output fields are checked after each streamed write.

// File: rtl/crp_pkg.sv
package crp_pkg;

  typedef enum logic [1:0] {
    PORT_PTR_LO = 2'd0,
    PORT_PTR_HI = 2'd1,
    PORT_MAP    = 2'd2,
    PORT_CTRL   = 2'd3
  } port_e;

  localparam int NUM_CTRL = 13;

  // control register indices; the order is decoded by the pixel stage
  localparam int IDX_CMD  = 0;
  localparam int IDX_CX_L = 1;

  typedef struct packed {
    logic       spare;
    logic       cursor_on;
    logic       xhair_on;
    logic       or_mode;
    logic [1:0] mux_sel;
    logic [1:0] thick_sel;
  } cmd_t;

  // high-byte coordinate registers sit at even nonzero indices
  function automatic bit is_high_half(input int idx);
    return (idx != 0) && ((idx % 2) == 0);
  endfunction

endpackage

// File: rtl/crp_pointer.sv
module crp_pointer #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_lo,
  input  logic             load_hi,
  input  logic             step,
  input  logic [PTR_W/2-1:0] load_val,
  output logic [PTR_W-1:0] ptr
);
  localparam int HALF = PTR_W / 2;

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_d = ptr_q;
    if (load_lo)      ptr_d = {ptr_q[PTR_W-1:HALF], load_val};
    else if (load_hi) ptr_d = {load_val, ptr_q[HALF-1:0]};
    else if (step)    ptr_d = ptr_q + 1'b1;
  end

  assign ptr_en = load_lo | load_hi | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R6: a data step from the all-ones value lands on zero
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_lo && !load_hi && (&ptr_q)) |=> (ptr_q == '0));

  // R1: a high-byte load leaves the low byte alone
  p_hi_load_keeps_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi && !load_lo) |=> (ptr_q[HALF-1:0] == $past(ptr_q[HALF-1:0])));

endmodule

// File: rtl/crp_ctrl_regs.sv
module crp_ctrl_regs
  import crp_pkg::*;
#(
  parameter int NREG    = NUM_CTRL,
  parameter int IDX_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int HI_BITS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [BYTE_W-1:0]      wr_byte,
  output logic [BYTE_W-1:0]      rd_byte,
  output logic [NREG*BYTE_W-1:0] regs_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] KEEP =
      is_high_half(g) ? BYTE_W'((1 << HI_BITS) - 1) : {BYTE_W{1'b1}};

    logic              hit;
    logic [BYTE_W-1:0] val_d, val_q;

    assign hit   = wr_en && (idx == IDX_W'(g));
    assign val_d = wr_byte & KEEP;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= val_d;
    end

    assign regs_flat[g*BYTE_W +: BYTE_W] = val_q;
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NREG; k++) begin
      if (idx == IDX_W'(k)) rd_byte = regs_flat[k*BYTE_W +: BYTE_W];
    end
  end

  // R10: writes beyond the register range leave every register unchanged
  p_oob_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx >= IDX_W'(NREG))) |=> $stable(regs_flat));

  // R10: reads beyond the register range return zero
  p_oob_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx >= IDX_W'(NREG)) |-> (rd_byte == '0));

endmodule

// File: rtl/crp_host_seq.sv
module crp_host_seq
  import crp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  logic  we,
  input  port_e port,
  output logic  ready,
  output logic  ld_lo,
  output logic  ld_hi,
  output logic  step,
  output logic  ctrl_wr,
  output logic  ctrl_rd,
  output logic  map_re,
  output logic  map_we,
  output logic  from_map
);

  typedef enum logic {SEQ_IDLE, SEQ_MAP_WAIT} seq_e;

  seq_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    ready    = 1'b0;
    ld_lo    = 1'b0;
    ld_hi    = 1'b0;
    step     = 1'b0;
    ctrl_wr  = 1'b0;
    ctrl_rd  = 1'b0;
    map_re   = 1'b0;
    map_we   = 1'b0;
    from_map = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (req) begin
          case (port)
            PORT_PTR_LO: begin
              ld_lo = we;
              ready = 1'b1;
            end
            PORT_PTR_HI: begin
              ld_hi = we;
              ready = 1'b1;
            end
            PORT_CTRL: begin
              ctrl_wr = we;
              ctrl_rd = !we;
              step    = 1'b1;
              ready   = 1'b1;
            end
            default: begin
              step = 1'b1;
              if (we) begin
                map_we = 1'b1;
                ready  = 1'b1;
              end else begin
                map_re  = 1'b1;
                state_d = SEQ_MAP_WAIT;
              end
            end
          endcase
        end
      end
      default: begin
        ready    = 1'b1;
        from_map = 1'b1;
        state_d  = SEQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R8: a map read strobe is answered on the following cycle
  p_map_rsp_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    map_re |=> (ready && from_map));

  // R8: nothing new is issued while a map read is outstanding
  p_no_issue_in_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    map_re |=> (!map_re && !map_we && !step && !ctrl_wr));

  // R7: a map write completes in the cycle it is strobed
  p_map_we_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> ready);

  // strobes toward the two address spaces are exclusive
  p_strobe_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({map_re, map_we, ctrl_wr, ctrl_rd, ld_lo, ld_hi}));

endmodule

// File: rtl/cursor_regport.sv
module cursor_regport
  import crp_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int MAP_AW  = 9,
  parameter int HI_BITS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_req,
  input  logic                      host_we,
  input  logic [1:0]                host_port,
  input  logic [2*BYTE_W-1:0]       host_wdata,
  output logic                      host_ready,
  output logic [2*BYTE_W-1:0]       host_rdata,
  output logic                      map_re,
  output logic                      map_we,
  output logic [MAP_AW-1:0]         map_addr,
  output logic [2*BYTE_W-1:0]       map_wdata,
  input  logic [2*BYTE_W-1:0]       map_rdata,
  output logic                      cursor_en,
  output logic                      xhair_en,
  output logic                      or_combine,
  output logic [1:0]                mux_mode,
  output logic [1:0]                xhair_thick,
  output logic [BYTE_W+HI_BITS-1:0] cursor_x,
  output logic [BYTE_W+HI_BITS-1:0] cursor_y,
  output logic [BYTE_W+HI_BITS-1:0] win_x,
  output logic [BYTE_W+HI_BITS-1:0] win_y,
  output logic [BYTE_W+HI_BITS-1:0] win_w,
  output logic [BYTE_W+HI_BITS-1:0] win_h
);
  localparam int BUS_W   = 2 * BYTE_W;
  localparam int COORD_W = BYTE_W + HI_BITS;
  localparam int NCOORD  = (NUM_CTRL - 1) / 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  port_e                   port;
  logic                    ld_lo, ld_hi, step, ctrl_wr, ctrl_rd, from_map;
  logic [PTR_W-1:0]        ptr;
  logic [BYTE_W-1:0]       ctrl_byte;
  logic [NUM_CTRL*BYTE_W-1:0] regs_flat;

  assign port = port_e'(host_port);

  crp_host_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .req      (host_req),
    .we       (host_we),
    .port     (port),
    .ready    (host_ready),
    .ld_lo    (ld_lo),
    .ld_hi    (ld_hi),
    .step     (step),
    .ctrl_wr  (ctrl_wr),
    .ctrl_rd  (ctrl_rd),
    .map_re   (map_re),
    .map_we   (map_we),
    .from_map (from_map)
  );

  crp_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_lo  (ld_lo),
    .load_hi  (ld_hi),
    .step     (step),
    .load_val (host_wdata[BYTE_W-1:0]),
    .ptr      (ptr)
  );

  crp_ctrl_regs #(
    .NREG    (NUM_CTRL),
    .IDX_W   (PTR_W),
    .BYTE_W  (BYTE_W),
    .HI_BITS (HI_BITS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (ctrl_wr),
    .idx       (ptr),
    .wr_byte   (host_wdata[BYTE_W-1:0]),
    .rd_byte   (ctrl_byte),
    .regs_flat (regs_flat)
  );

  // map RAM side
  assign map_addr  = ptr[MAP_AW-1:0];
  assign map_wdata = host_wdata;

  // host read path
  always_comb begin
    host_rdata = '0;
    if (from_map)     host_rdata = map_rdata;
    else if (ctrl_rd) host_rdata = {ctrl_byte, ctrl_byte};
  end

  // field decode for the pixel stage
  cmd_t cmd;
  assign cmd         = cmd_t'(regs_flat[IDX_CMD*BYTE_W +: BYTE_W]);
  assign cursor_en   = cmd.cursor_on;
  assign xhair_en    = cmd.xhair_on;
  assign or_combine  = cmd.or_mode;
  assign mux_mode    = cmd.mux_sel;
  assign xhair_thick = cmd.thick_sel;

  logic [NCOORD-1:0][COORD_W-1:0] coord;
  for (genvar c = 0; c < NCOORD; c++) begin : g_coord
    localparam int LO_IDX = IDX_CX_L + 2 * c;
    assign coord[c] = {regs_flat[(LO_IDX+1)*BYTE_W +: HI_BITS],
                       regs_flat[LO_IDX*BYTE_W +: BYTE_W]};
  end

  assign cursor_x = coord[0];
  assign cursor_y = coord[1];
  assign win_x    = coord[2];
  assign win_y    = coord[3];
  assign win_w    = coord[4];
  assign win_h    = coord[5];

  // R5: each data access moves the pointer forward by one
  p_step_by_one_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_req && host_ready && !from_map &&
     (port == PORT_CTRL || port == PORT_MAP)) |=> (ptr == $past(ptr) + 1'b1));

  // R1: a low-byte load takes bits [7:0] and keeps the high byte
  p_lo_load_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_req && host_we && port == PORT_PTR_LO && host_ready) |=>
    (ptr == {$past(ptr[PTR_W-1:BYTE_W]), $past(host_wdata[BYTE_W-1:0])}));

  // R2: a control read mirrors its byte on both halves
  p_ctrl_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_ready && port == PORT_CTRL && !host_we) |->
    (host_rdata[BUS_W-1:BYTE_W] == host_rdata[BYTE_W-1:0]));

  // R4: high coordinate registers never hold upper bits
  p_hi_nibble_clear_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (regs_flat[2*BYTE_W +: BYTE_W] >> HI_BITS) == '0);

endmodule

// File: tb/cursor_regport_test.sv
`timescale 1ns/1ps
module cursor_regport_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [1:0]  host_port;
  logic [15:0] host_wdata;
  logic        host_ready;
  logic [15:0] host_rdata;
  logic        map_re, map_we;
  logic [8:0]  map_addr;
  logic [15:0] map_wdata, map_rdata;
  logic        cursor_en, xhair_en, or_combine;
  logic [1:0]  mux_mode, xhair_thick;
  logic [11:0] cursor_x, cursor_y, win_x, win_y, win_w, win_h;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  logic [15:0] ram [512];
  logic [15:0] ram_q;

  always #2.5 clk = ~clk;

  cursor_regport uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_port(host_port), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .map_re(map_re), .map_we(map_we),
    .map_addr(map_addr), .map_wdata(map_wdata), .map_rdata(map_rdata),
    .cursor_en(cursor_en), .xhair_en(xhair_en), .or_combine(or_combine),
    .mux_mode(mux_mode), .xhair_thick(xhair_thick), .cursor_x(cursor_x),
    .cursor_y(cursor_y), .win_x(win_x), .win_y(win_y), .win_w(win_w),
    .win_h(win_h)
  );

  // external synchronous map RAM
  always @(posedge clk) begin
    if (map_we) ram[map_addr] <= map_wdata;
    if (map_re) ram_q <= ram[map_addr];
  end
  assign map_rdata = ram_q;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected word per completed data read
  always @(negedge clk) begin
    #2;
    if (!done && rst_n && host_req && host_ready && !host_we && host_port[1]) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard unexpected read actual=%h expected=none", host_rdata);
      end else begin
        chk(tag_q.pop_front(), {16'h0, host_rdata}, {16'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic acc(input logic [1:0] p, input logic we, input logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1; host_port = p; host_we = we; host_wdata = d;
    #1;
    while (!host_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    host_req = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    acc(2'd0, 1'b1, {8'hA5, a[7:0]});
    acc(2'd1, 1'b1, {8'h5A, a[15:8]});
  endtask

  task automatic exp_read(input logic [1:0] p, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc(p, 1'b0, 16'h0);
  endtask

  logic [7:0] wvals [13];
  logic [7:0] kvals [13];

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    host_req = 0; host_we = 0; host_port = 0; host_wdata = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // R11: reset state of the outputs
    chk("R11 cmd fields at reset", {27'h0, cursor_en, xhair_en, or_combine, mux_mode},
        32'h0);
    chk("R11 coords at reset", {8'h0, cursor_x, cursor_y}, 32'h0);
    chk("R11 window at reset", {win_x, win_y, win_w, win_h} == 48'h0, 32'h1);

    // R11: pointer starts at zero, so the first read hits the command register
    exp_read(2'd3, 16'h0000, "R11 first read at pointer zero");
    // pointer is now 1; reload to 0 via low-byte port with junk in bits [15:8] (R1)
    acc(2'd0, 1'b1, 16'hEE00);

    // R3 R2: stream all thirteen registers, junk in the high byte
    wvals = '{8'h75, 8'h34, 8'hF7, 8'h56, 8'h02, 8'h11, 8'h03,
              8'h22, 8'h0A, 8'h33, 8'h05, 8'h44, 8'hE6};
    for (int i = 0; i < 13; i++) begin
      kvals[i] = ((i != 0) && (i % 2 == 0)) ? (wvals[i] & 8'h0F) : wvals[i];
      acc(2'd3, 1'b1, {8'hC3, wvals[i]});
    end

    // R9: command 0x75
    chk("R9 cursor_en", {31'h0, cursor_en}, 32'h1);
    chk("R9 xhair_en", {31'h0, xhair_en}, 32'h1);
    chk("R9 or_combine", {31'h0, or_combine}, 32'h1);
    chk("R9 mux_mode", {30'h0, mux_mode}, 32'h1);
    chk("R9 xhair_thick", {30'h0, xhair_thick}, 32'h1);
    // R3 R4: coordinate assembly and nibble masking
    chk("R4 cursor_x", {20'h0, cursor_x}, 32'h734);
    chk("R3 cursor_y", {20'h0, cursor_y}, 32'h256);
    chk("R3 win_x", {20'h0, win_x}, 32'h311);
    chk("R3 win_y", {20'h0, win_y}, 32'hA22);
    chk("R3 win_w", {20'h0, win_w}, 32'h533);
    chk("R4 win_h", {20'h0, win_h}, 32'h644);

    // R5 R10: the stream ended at pointer 0x000D; writes there are ignored
    acc(2'd3, 1'b1, 16'h00FF);
    exp_read(2'd3, 16'h0000, "R10 read at 0x000E is zero");
    set_ptr(16'h000D);
    exp_read(2'd3, 16'h0000, "R10 read at 0x000D is zero");
    set_ptr(16'h0100);
    acc(2'd3, 1'b1, 16'h0000);
    chk("R10 write at 0x0100 ignored", {31'h0, cursor_en}, 32'h1);
    chk("R10 coords untouched", {20'h0, win_h}, 32'h644);

    // R2 R4 R5: read back the whole file as a stream
    set_ptr(16'h0000);
    for (int i = 0; i < 13; i++)
      exp_read(2'd3, {kvals[i], kvals[i]}, $sformatf("R2 stream read idx %0d", i));

    // R1: low-byte load ignores bits [15:8] and keeps high byte
    acc(2'd1, 1'b1, 16'h9900);
    acc(2'd0, 1'b1, 16'hEE0C);
    exp_read(2'd3, 16'h0606, "R1 low-byte load to 0x000C");

    // R9: second command pattern
    set_ptr(16'h0000);
    acc(2'd3, 1'b1, 16'h000A);
    chk("R9 cmd 0x0A enables", {30'h0, cursor_en, xhair_en}, 32'h0);
    chk("R9 cmd 0x0A or", {31'h0, or_combine}, 32'h0);
    chk("R9 cmd 0x0A mux", {30'h0, mux_mode}, 32'h2);
    chk("R9 cmd 0x0A thick", {30'h0, xhair_thick}, 32'h2);

    // R7: map stream across the 0x1FF boundary into address 0 (pointer 0x0200)
    set_ptr(16'h01FE);
    acc(2'd2, 1'b1, 16'hBEEF);
    acc(2'd2, 1'b1, 16'h1234);
    acc(2'd2, 1'b1, 16'hF00D);
    set_ptr(16'h0000);
    // R8: map read of address 0 then 1 (address 1 unwritten, write it first)
    set_ptr(16'h0001);
    acc(2'd2, 1'b1, 16'h8001);
    set_ptr(16'h01FE);
    exp_read(2'd2, 16'hBEEF, "R8 map read 0x1FE");
    exp_read(2'd2, 16'h1234, "R8 map read 0x1FF");
    exp_read(2'd2, 16'hF00D, "R7 map read pointer 0x200 maps to 0");
    exp_read(2'd2, 16'h8001, "R8 map read streams to 0x201");

    // R6: pointer wrap, ignored write at 0xFFFF, then read at 0x0000
    set_ptr(16'hFFFF);
    acc(2'd3, 1'b1, 16'h0055);
    exp_read(2'd3, 16'h0A0A, "R6 wrap to command register");
    // R6 via map: wrap after map read at 0xFFFF (map address 0x1FF)
    set_ptr(16'hFFFF);
    exp_read(2'd2, 16'h1234, "R6 map read at 0xFFFF");
    exp_read(2'd3, 16'h0A0A, "R6 map step wraps to zero");

    repeat (3) @(posedge clk);
    #1;
    chk("R8 scoreboard drained", exp_q.size(), 32'h0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule